// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block turns single-word read and write requests, each carrying a flat word address, into the strobe sequence that an asynchronous DRAM with a multiplexed address bus expects. The upper address bits select a row and the lower bits select a column. Both halves travel over the same address pins: the row is presented while the row strobe falls and the column while the column strobe falls. After an access the row is left open, so a following request to the same row needs only a column strobe cycle. A request to a different row first closes the open row for a minimum precharge time and then opens the new one.

Every timing limit is given in nanoseconds and turned into a clock-cycle count, rounded up, from the clock period parameter. Down-counters hold back each strobe edge until its limit has been met. The limits are the row-to-data and column-to-data access times, the row-cycle and column-cycle spacings, and the precharge time. A refresh timer splits the refresh window evenly over all rows. When it expires, the controller closes any open row and performs one row-strobe-only cycle on an incrementing refresh row, between two requests. Requests use a valid/ready handshake. Read data comes back with a one-cycle valid pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, all four active-low strobes (row, column, write enable, output enable) are high, the data-drive enable is low, and the controller is ready for a request.
- R2: On an access to a closed row, the row strobe falls with the row (address bits [21:11]) on the address pins. Later, the column strobe falls with the column (bits [10:0]) on the pins. The pins hold the column for at least one cycle before that fall, and the column strobe is only low while the row strobe is low.
- R3: A request to the row that is already open does not make the row strobe rise or fall again. Only the column strobe cycles.
- R4: Read data is sampled no sooner than the row-to-data access time after the row strobe falls and the column-to-data access time after the column strobe falls. It is returned on the read data port with a valid pulse one cycle long.
- R5: Consecutive row strobe falls are at least the row-cycle time apart. Consecutive column strobe falls are at least the column-cycle time apart.
- R6: For a write, write enable is low from at least one cycle before the column strobe falls, output enable is high, and the write data is driven with the drive enable high. For a read, write enable is high and output enable is low. The two enables are never low together.
- R7: When a request goes to a different row than the open one, the row strobe stays high for at least the precharge time before it falls again.
- R8: Refresh becomes due every (refresh window / clock period / row count) cycles. A refresh is a row-strobe cycle with the column strobe held high, on a refresh row that goes up by one each time. It closes any open row, so the next access opens its row afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller accepts a request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Flat word address, row in upper bits |
| req_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | One-cycle pulse with read data |
| rd_data_o | output | 8 | Read data |
| row_stb_n_o | output | 1 | Row address strobe, active low |
| col_stb_n_o | output | 1 | Column address strobe, active low |
| wr_en_n_o | output | 1 | Write enable, active low |
| out_en_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | 11 | Multiplexed row/column address |
| dq_i | input | 8 | Data from the memory |
| dq_o | output | 8 | Data to the memory |
| dq_oe_o | output | 1 | Drive enable for dq_o |

## Verification
With a 10 ns clock, the column strobe falls 4 cycles after the row strobe opens a row. Read data is sampled 2 cycles after the column strobe falls, and the valid pulse shows up on the cycle that follows. Row closes precede reopening by at least 4 cycles, and refreshes come every 390 cycles. The bench's memory model drives valid data only once the rounded-up access times have passed since each strobe fell, and drives inverted junk before that, so early sampling shows up as wrong read data. The model also measures strobe spacings at falling clock edges. Requests and results are exchanged at falling edges, and each result wait is bounded, so every sample falls in a settled half-cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_OPEN, ST_COL, ST_DATA, ST_REF
  } fpm_state_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_hold_cnt.sv
module fpm_hold_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpm_refresh_tmr.sv
module fpm_refresh_tmr #(
  parameter int unsigned INTERVAL = 390,
  parameter int unsigned ROW_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned TW = $clog2(INTERVAL + 1);
  logic [TW-1:0] tmr_q;
  logic          tick;

  assign tick = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= TW'(INTERVAL - 1);
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      tmr_q <= tick ? TW'(INTERVAL - 1) : tmr_q - 1'b1;
      if (ack_i) row_o <= row_o + 1'b1;
      if (tick)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned ROW_W       = 11,
  parameter int unsigned COL_W       = 11,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned T_RAC_NS    = 60,
  parameter int unsigned T_CAC_NS    = 15,
  parameter int unsigned T_RC_NS     = 110,
  parameter int unsigned T_PC_NS     = 35,
  parameter int unsigned T_RP_NS     = 40,
  parameter int unsigned REF_WIN_NS  = 8_000_000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_write_i,
  input  logic [ROW_W+COL_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      rd_valid_o,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic                      row_stb_n_o,
  output logic                      col_stb_n_o,
  output logic                      wr_en_n_o,
  output logic                      out_en_n_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  input  logic [DATA_W-1:0]         dq_i,
  output logic [DATA_W-1:0]         dq_o,
  output logic                      dq_oe_o
);
  localparam int unsigned ADDR_W  = ROW_W + COL_W;
  localparam int unsigned PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned RAC_CYC = ns2cyc(T_RAC_NS, CLK_NS);
  localparam int unsigned CAC_CYC = ns2cyc(T_CAC_NS, CLK_NS);
  localparam int unsigned RC_CYC  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned PC_CYC  = ns2cyc(T_PC_NS, CLK_NS);
  localparam int unsigned RP_CYC  = ns2cyc(T_RP_NS, CLK_NS);
  localparam int unsigned RCD_CYC = (RAC_CYC > CAC_CYC) ? RAC_CYC - CAC_CYC : 1;
  localparam int unsigned REF_INT = REF_WIN_NS / CLK_NS / (1 << ROW_W);
  localparam int unsigned MAX_CYC = max_u(max_u(RC_CYC, RAC_CYC), max_u(PC_CYC, RP_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  fpm_state_e         state_q;
  logic               row_open_q, have_req_q, staged_q;
  logic [ROW_W-1:0]   open_row_q, req_row_q, ref_row;
  logic [COL_W-1:0]   req_col_q;
  logic [DATA_W-1:0]  req_dat_q;
  logic               req_wr_q;
  logic               ref_pend, rc_zero, pc_zero, wt_zero;
  logic               ras_open, ras_ref, ras_close, cas_fall, accept;
  logic [CNT_W-1:0]   wt_val;

  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend;
  assign accept      = req_ready_o && req_valid_i;
  assign ras_open    = (state_q == ST_OPEN) && rc_zero;
  assign ras_ref     = (state_q == ST_IDLE) && ref_pend && !row_open_q && rc_zero;
  assign ras_close   = ((state_q == ST_IDLE) && row_open_q &&
                        (ref_pend || (accept && req_addr_i[ADDR_W-1:COL_W] != open_row_q)))
                     || ((state_q == ST_REF) && wt_zero);
  assign cas_fall    = (state_q == ST_COL) && staged_q && wt_zero && pc_zero;

  always_comb begin
    wt_val = '0;
    if (ras_close)     wt_val = CNT_W'(RP_CYC - 1);
    else if (ras_open) wt_val = CNT_W'(RCD_CYC - 1);
    else if (ras_ref)  wt_val = CNT_W'(RAC_CYC - 1);  // minimum low time of a refresh
    else if (cas_fall) wt_val = CNT_W'(CAC_CYC - 1);
  end

  fpm_hold_cnt #(.W(CNT_W)) u_rc (.clk_i, .rst_ni, .load_i(ras_open || ras_ref),
                                  .val_i(CNT_W'(RC_CYC - 1)), .zero_o(rc_zero));
  fpm_hold_cnt #(.W(CNT_W)) u_pc (.clk_i, .rst_ni, .load_i(cas_fall),
                                  .val_i(CNT_W'(PC_CYC - 1)), .zero_o(pc_zero));
  fpm_hold_cnt #(.W(CNT_W)) u_wt (.clk_i, .rst_ni,
                                  .load_i(ras_close || ras_open || ras_ref || cas_fall),
                                  .val_i(wt_val), .zero_o(wt_zero));
  fpm_refresh_tmr #(.INTERVAL(REF_INT), .ROW_W(ROW_W)) u_ref (
    .clk_i, .rst_ni, .ack_i(ras_ref), .pend_o(ref_pend), .row_o(ref_row));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_stb_n_o <= 1'b1;
      col_stb_n_o <= 1'b1;
      wr_en_n_o   <= 1'b1;
      out_en_n_o  <= 1'b1;
      dq_oe_o     <= 1'b0;
      dq_o        <= '0;
      dram_addr_o <= '0;
      row_open_q  <= 1'b0;
      open_row_q  <= '0;
      have_req_q  <= 1'b0;
      staged_q    <= 1'b0;
      req_row_q   <= '0;
      req_col_q   <= '0;
      req_dat_q   <= '0;
      req_wr_q    <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      if (ras_close) begin
        row_stb_n_o <= 1'b1;
        row_open_q  <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (ref_pend) begin
            if (row_open_q) state_q <= ST_PRE;
            else if (ras_ref) begin
              row_stb_n_o <= 1'b0;
              dram_addr_o <= PIN_W'(ref_row);
              state_q     <= ST_REF;
            end
          end else if (accept) begin
            req_row_q  <= req_addr_i[ADDR_W-1:COL_W];
            req_col_q  <= req_addr_i[COL_W-1:0];
            req_dat_q  <= req_wdata_i;
            req_wr_q   <= req_write_i;
            have_req_q <= 1'b1;
            if (!row_open_q)  state_q <= ST_OPEN;
            else if (ras_close) state_q <= ST_PRE;
            else              state_q <= ST_COL;
          end
        end
        ST_PRE:  if (wt_zero) state_q <= have_req_q ? ST_OPEN : ST_IDLE;
        ST_OPEN: if (ras_open) begin
          row_stb_n_o <= 1'b0;
          dram_addr_o <= PIN_W'(req_row_q);
          row_open_q  <= 1'b1;
          open_row_q  <= req_row_q;
          state_q     <= ST_COL;
        end
        ST_COL: begin
          if (!staged_q) begin  // column and enables settle one cycle ahead of the strobe
            dram_addr_o <= PIN_W'(req_col_q);
            wr_en_n_o   <= !req_wr_q;
            out_en_n_o  <= req_wr_q;
            dq_oe_o     <= req_wr_q;
            dq_o        <= req_dat_q;
            staged_q    <= 1'b1;
          end else if (cas_fall) begin
            col_stb_n_o <= 1'b0;
            staged_q    <= 1'b0;
            state_q     <= ST_DATA;
          end
        end
        ST_DATA: if (wt_zero) begin
          if (!req_wr_q) begin
            rd_valid_o <= 1'b1;
            rd_data_o  <= dq_i;
          end
          col_stb_n_o <= 1'b1;
          wr_en_n_o   <= 1'b1;
          out_en_n_o  <= 1'b1;
          dq_oe_o     <= 1'b0;
          have_req_q  <= 1'b0;
          state_q     <= ST_IDLE;
        end
        ST_REF:  if (wt_zero) state_q <= ST_PRE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int unsigned PIN_W  = 11,
  parameter int unsigned RC_CYC = 11,
  parameter int unsigned PC_CYC = 4,
  parameter int unsigned RP_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             row_stb_n_o,
  input logic             col_stb_n_o,
  input logic             wr_en_n_o,
  input logic             out_en_n_o,
  input logic             dq_oe_o,
  input logic             rd_valid_o,
  input logic [PIN_W-1:0] dram_addr_o
);
  logic [7:0] since_ras, since_cas, ras_high;
  logic       ras_q, cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_ras <= 8'hff;
      since_cas <= 8'hff;
      ras_high  <= 8'hff;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
    end else begin
      ras_q <= row_stb_n_o;
      cas_q <= col_stb_n_o;
      if (ras_q && !row_stb_n_o)  since_ras <= 8'd1;
      else if (since_ras != 8'hff) since_ras <= since_ras + 8'd1;
      if (cas_q && !col_stb_n_o)  since_cas <= 8'd1;
      else if (since_cas != 8'hff) since_cas <= since_cas + 8'd1;
      if (!row_stb_n_o)            ras_high <= 8'd0;
      else if (ras_high != 8'hff)  ras_high <= ras_high + 8'd1;
    end
  end

  AST_ENABLES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_en_n_o && !out_en_n_o)); // R6
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!wr_en_n_o && out_en_n_o)); // R6
  AST_EARLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(col_stb_n_o) && !wr_en_n_o) |-> !$past(wr_en_n_o)); // R6
  AST_COL_IN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_stb_n_o |-> !row_stb_n_o); // R2
  AST_COL_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(col_stb_n_o) |-> $stable(dram_addr_o)); // R2
  AST_ROW_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_stb_n_o) |-> (since_ras >= 8'(RC_CYC))); // R5
  AST_COL_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(col_stb_n_o) |-> (since_cas >= 8'(PC_CYC))); // R5
  AST_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_stb_n_o) |-> (ras_high >= 8'(RP_CYC))); // R7
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R4
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
  .PIN_W(PIN_W), .RC_CYC(RC_CYC), .PC_CYC(PC_CYC), .RP_CYC(RP_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .row_stb_n_o(row_stb_n_o), .col_stb_n_o(col_stb_n_o),
  .wr_en_n_o(wr_en_n_o), .out_en_n_o(out_en_n_o), .dq_oe_o(dq_oe_o),
  .rd_valid_o(rd_valid_o), .dram_addr_o(dram_addr_o)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  localparam int CLK = 10;
  localparam int RAC = (60 + CLK - 1) / CLK;
  localparam int CAC = (15 + CLK - 1) / CLK;
  localparam int RC  = (110 + CLK - 1) / CLK;
  localparam int PC  = (35 + CLK - 1) / CLK;
  localparam int RP  = (40 + CLK - 1) / CLK;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, dq_in = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [7:0]  rd_data, dq_out;
  logic [10:0] dpins;

  always #(CLK/2) clk = ~clk;

  fpm_dram_ctrl u_fpm_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .row_stb_n_o(ras_n), .col_stb_n_o(cas_n),
    .wr_en_n_o(we_n), .out_en_n_o(oe_n), .dram_addr_o(dpins), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model, observed at falling edges
  logic [7:0] mem [256];
  int cyc = 0, ras_fall_cyc = -100, ras_rise_cyc = -100, cas_fall_cyc = -100;
  int ras_id = 0, cas_ras_id = 0, ref_seen = 0, last_ref_row = 0;
  int rc_viol = 0, pc_viol = 0, rp_viol = 0, early_viol = 0, en_viol = 0, refseq_viol = 0;
  int row_l = 0, col_l = 0;
  logic cas_seen = 1'b0, p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [10:0] p_pins = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3c;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!we_n && !oe_n) en_viol++;
      if (p_ras && !ras_n) begin
        if (ras_id > 0 && cyc - ras_fall_cyc < RC) rc_viol++;
        if (ras_id > 0 && cyc - ras_rise_cyc < RP) rp_viol++;
        ras_fall_cyc = cyc; ras_id++; row_l = int'(dpins); cas_seen = 1'b0;
      end
      if (!p_ras && ras_n) begin
        ras_rise_cyc = cyc;
        if (!cas_seen) begin
          if (ref_seen > 0 && row_l != last_ref_row + 1) refseq_viol++;
          last_ref_row = row_l; ref_seen++;
        end
      end
      if (p_cas && !cas_n) begin
        if (cas_fall_cyc >= 0 && cyc - cas_fall_cyc < PC) pc_viol++;
        if (ras_n || dpins != p_pins) en_viol++;
        cas_fall_cyc = cyc; cas_seen = 1'b1; cas_ras_id = ras_id; col_l = int'(dpins);
        if (!we_n) begin
          if (p_we || !oe_n || !dq_oe) early_viol++;
          mem[{row_l[3:0], col_l[3:0]}] = dq_out;
        end else if (oe_n) en_viol++;
      end
      if (!cas_n && !oe_n && we_n)
        dq_in = (cyc - cas_fall_cyc + 1 >= CAC && cyc - ras_fall_cyc + 1 >= RAC)
              ? mem[{row_l[3:0], col_l[3:0]}] : ~mem[{row_l[3:0], col_l[3:0]}];
      else dq_in = 8'h00;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_pins = dpins;
  end

  function automatic logic [21:0] mk(input int row, input int col);
    return {11'(row), 11'(col)};
  endfunction

  task automatic issue(input logic wr, input logic [21:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input int row, input int col, input logic [7:0] d);
    issue(1'b1, mk(row, col), d);
    repeat (12) @(negedge clk);
  endtask

  task automatic do_read(input int row, input int col, output int d);
    int n = 0;
    issue(1'b0, mk(row, col), 8'h00);
    d = -1;
    while (n < 200) begin
      if (rd_valid) begin d = int'(rd_data); break; end
      @(negedge clk); n++;
    end
  endtask

  task automatic wait_refresh();
    int r0 = ref_seen, n = 0;
    while (ref_seen == r0 && n < 1000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 strobes high", int'({ras_n, cas_n, we_n, oe_n}), 15);
    chk("R1 drive enable low", int'(dq_oe), 0);
    chk("R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_new_row();
    int d;
    wait_refresh();
    do_write(5, 3, 8'h5a);
    chk("R2 row on pins at row strobe", row_l, 5);
    chk("R2 column on pins at col strobe", col_l, 3);
    do_read(5, 3, d);
    chk("R4 R6 read returns written word", d, 8'h5a);
  endtask

  task automatic t_page_hit();
    int d, id0;
    wait_refresh();
    do_write(6, 1, 8'hc3);
    id0 = cas_ras_id;
    do_write(6, 9, 8'h17);
    chk("R3 hit write keeps row open", cas_ras_id, id0);
    do_read(6, 1, d);
    chk("R3 hit read keeps row open", cas_ras_id, id0);
    chk("R3 R4 hit read data", d, 8'hc3);
    do_read(6, 9, d);
    chk("R3 second column data", d, 8'h17);
  endtask

  task automatic t_row_miss();
    int d, id0;
    wait_refresh();
    do_read(2, 4, d);
    id0 = cas_ras_id;
    chk("R4 read of untouched word", d, int'((8'h24) ^ 8'h3c));
    do_write(9, 4, 8'h81);
    chk("R7 miss opens new row", int'(cas_ras_id != id0), 1);
    chk("R7 new row on pins", row_l, 9);
    do_read(9, 4, d);
    chk("R7 data after miss", d, 8'h81);
    do_read(2, 4, d);
    chk("R7 back to first row", d, int'((8'h24) ^ 8'h3c));
  endtask

  task automatic t_refresh();
    int d, id0, r0;
    do_write(7, 2, 8'h66);
    id0 = cas_ras_id;
    wait_refresh();
    do_read(7, 2, d);
    chk("R8 refresh closed the row", int'(cas_ras_id != id0), 1);
    chk("R8 data kept over refresh", d, 8'h66);
    r0 = ref_seen;
    repeat (2000) @(negedge clk);
    chk("R8 refresh count in 2000 cycles", int'((ref_seen - r0) >= 5 && (ref_seen - r0) <= 6), 1);
    chk("R8 refresh row increments", refseq_viol, 0);
  endtask

  task automatic t_timing();
    chk("R5 row cycle spacing", rc_viol, 0);
    chk("R5 column cycle spacing", pc_viol, 0);
    chk("R7 precharge time", rp_viol, 0);
    chk("R6 early write", early_viol, 0);
    chk("R6 R2 enables and column strobe", en_viol, 0);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_new_row();
    t_page_hit();
    t_row_miss();
    t_refresh();
    t_timing();
    done = 1'b1;
  end

  initial begin
    int w = 0;
    while (!done && w < 100000) begin @(negedge clk); w++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected done", w);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule